// File: doc/BRIEF.md
# Configurable Stereo Serial Audio Receiver

This block receives a two-channel audio stream on four serial wires: a bit clock, a channel-select (left/right) clock, a word clock and a data line. It oversamples all four wires with the system clock and finds the active bit clock edge. It then assembles each channel word MSB first and delivers a left and a right parallel sample, each with a one-cycle valid strobe. Static configuration inputs choose the following:

- the word length;
- whether a frame starts at a channel-clock transition or at a rising word-clock edge;
- whether the first data bit sits on that edge or one bit later;
- which bit clock edge captures data;
- which channel-clock level means left.

Short words come out left-justified, with zeros in the low bits. The inputs are meant to change only between frames.

The control is a four-state machine. `ST_IDLE` waits after reset for the first frame start. `ST_SKIP` drops the one delay bit. `ST_SHIFT` collects data bits. `ST_HOLD` ignores the rest of a slot after delivery. The transitions are:

- **start**: any state goes to `ST_SHIFT` on a frame start with no delay, or to `ST_SKIP` with delay.
- **first**: `ST_SKIP` goes to `ST_SHIFT` on the next active edge.
- **deliver**: `ST_SHIFT` goes to `ST_HOLD` when the last programmed bit arrives.
- **wait**: `ST_HOLD` and `ST_IDLE` stay where they are until the next frame start.

A frame start is found by comparing the channel or word clock level at this active bit clock edge with the level registered at the previous active edge.

Top module: `asr_stereo_rx`

## Requirements
- R1: While `rst_n` is low and right after reset, `left_vld` and `right_vld` are 0 and `left_data` and `right_data` are all zeros.
- R2: The word length is `cfg_wlen` clamped to the range 4..20: values below 4 act as 4 and values above 20 act as 20.
- R3: A word of length L lands in bits [19:20-L] with its first serial bit in bit 19, and bits [19-L:0] are zero.
- R4: With `cfg_wck_sel`=0 and `cfg_late`=0, a frame starts when the channel clock level at an active bit clock edge differs from its level at the previous active edge. The bit captured at that edge is the MSB.
- R5: With `cfg_late`=1, the bit at the frame-start edge is dropped and the MSB is taken at the next active edge.
- R6: With `cfg_wck_sel`=1, a frame starts only when the word clock is 1 at an active edge after being 0 at the previous one. Channel clock transitions then start nothing, and the channel is the channel clock level at the word clock rising edge.
- R7: `cfg_neg_edge`=0 captures data on rising bit clock edges, and `cfg_neg_edge`=1 captures on falling edges.
- R8: A frame whose channel clock level is 1 is the left channel when `cfg_left_low`=0. When `cfg_left_low`=1, level 0 is left.
- R9: Each completed word gives exactly one one-cycle pulse on the valid of its channel. The data output changes only in that cycle and holds its value until the next pulse.
- R10: Bits that arrive after the programmed word length, before the next frame start, do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low reset |
| ser_bclk | input | 1 | Serial bit clock |
| ser_lrclk | input | 1 | Channel-select clock |
| ser_wclk | input | 1 | Word clock |
| ser_data | input | 1 | Serial data |
| cfg_wlen | input | 5 | Requested word length (clamped to 4..20) |
| cfg_late | input | 1 | 1: MSB one bit after the frame start |
| cfg_wck_sel | input | 1 | 1: frame on word clock rising edge |
| cfg_neg_edge | input | 1 | 1: capture on falling bit clock edge |
| cfg_left_low | input | 1 | 1: channel clock low means left |
| left_data | output | 20 | Left sample, left-justified |
| left_vld | output | 1 | One-cycle strobe for left_data |
| right_data | output | 20 | Right sample, left-justified |
| right_vld | output | 1 | One-cycle strobe for right_data |

## Verification
The bench builds the receiver with its defaults: a 20-bit maximum word, a 4-bit minimum and a two-stage input synchronizer. It drives a bit clock at one eighth of the system clock, so each serial bit spans eight oversampling cycles.

With these values every word length from 4 to 20 is reachable. So are out-of-range requests on both sides of the clamp, and a word-clock offset plus one delay bit still fits inside a 24-bit slot. Junk bits after each word and before a word-clock start exercise the ignore rules. Random configurations are mixed with directed frames for every framing, polarity and channel mapping.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } rx_state_t;

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned CH_LEFT  = 0;
    localparam int unsigned CH_RIGHT = 1;

    // Limit a requested word length to the supported range.
    function automatic int unsigned clamp_len(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (req < lo)
            return lo;
        if (req > hi)
            return hi;
        return req;
    endfunction

endpackage

// File: rtl/asr_bclk_edge.sv
`timescale 1ns/1ps
module asr_bclk_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_bclk,
    input  logic raw_lrclk,
    input  logic raw_wclk,
    input  logic raw_data,
    input  logic neg_edge,
    output logic act,
    output logic bit_o,
    output logic lr_o,
    output logic wck_o
);

    localparam int unsigned NSIG = 4;
    localparam int unsigned I_BCLK = 0;
    localparam int unsigned I_LR   = 1;
    localparam int unsigned I_WCK  = 2;
    localparam int unsigned I_DAT  = 3;

    logic [NSIG-1:0] raw_vec;
    logic [NSIG-1:0] stg [STAGES];
    logic [NSIG-1:0] sync_vec;
    logic            bclk_prev;

    assign raw_vec = {raw_data, raw_wclk, raw_lrclk, raw_bclk};

    // All four wires pass through the same number of stages, so the data
    // stays aligned with the clock edge that samples it.
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg[g] <= '0;
                else
                    stg[g] <= raw_vec;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg[g] <= '0;
                else
                    stg[g] <= stg[g-1];
            end
        end
    end

    assign sync_vec = stg[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bclk_prev <= 1'b0;
        else
            bclk_prev <= sync_vec[I_BCLK];
    end

    always_comb begin
        if (neg_edge)
            act = bclk_prev & ~sync_vec[I_BCLK];
        else
            act = ~bclk_prev & sync_vec[I_BCLK];
    end

    assign bit_o = sync_vec[I_DAT];
    assign lr_o  = sync_vec[I_LR];
    assign wck_o = sync_vec[I_WCK];

    // R7: an active edge needs a level change, so two never come back to back.
    p_act_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !act);

endmodule

// File: rtl/asr_frame_fsm.sv
`timescale 1ns/1ps
module asr_frame_fsm
    import asr_pkg::*;
#(
    parameter int unsigned MAXW = 20,
    parameter int unsigned MINW = 4,
    parameter int unsigned LENW = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act,
    input  logic            bit_i,
    input  logic            lr_i,
    input  logic            wck_i,
    input  logic [LENW-1:0] cfg_wlen,
    input  logic            cfg_late,
    input  logic            cfg_wck_sel,
    input  logic            cfg_left_low,
    output logic            fin,
    output logic            fin_left,
    output logic [MAXW-1:0] word
);

    localparam int unsigned CW = $clog2(MAXW + 1);

    rx_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d, cnt_inc;
    logic [MAXW-1:0] sh_q, sh_d;
    logic [MAXW-1:0] ins_bit, msb_word;
    logic            left_q, left_d;
    logic            lr_prev_q, wck_prev_q;
    logic            ev_lr, ev_wck, ev;
    logic [CW-1:0]   wlen_c;

    always_comb wlen_c = CW'(clamp_len(32'(cfg_wlen), MINW, MAXW));

    // Frame start: compare the level now with the level at the last active edge.
    always_comb begin
        ev_lr  = lr_i != lr_prev_q;
        ev_wck = wck_i & ~wck_prev_q;
        ev     = act & (cfg_wck_sel ? ev_wck : ev_lr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev_q  <= 1'b0;
            wck_prev_q <= 1'b0;
        end else if (act) begin
            lr_prev_q  <= lr_i;
            wck_prev_q <= wck_i;
        end
    end

    always_comb begin
        cnt_inc  = cnt_q + CW'(1);
        msb_word = {bit_i, {(MAXW-1){1'b0}}};
        ins_bit  = {{(MAXW-1){1'b0}}, bit_i} << (CW'(MAXW - 1) - cnt_q);
    end

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        left_d  = left_q;
        fin     = 1'b0;
        if (act) begin
            if (ev) begin
                // start
                left_d = lr_i ^ cfg_left_low;
                if (cfg_late) begin
                    sh_d    = '0;
                    cnt_d   = '0;
                    state_d = ST_SKIP;
                end else begin
                    sh_d    = msb_word;
                    cnt_d   = CW'(1);
                    state_d = ST_SHIFT;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        state_d = ST_IDLE;
                    end
                    ST_SKIP: begin
                        // first
                        sh_d    = msb_word;
                        cnt_d   = CW'(1);
                        state_d = ST_SHIFT;
                    end
                    ST_SHIFT: begin
                        sh_d  = sh_q | ins_bit;
                        cnt_d = cnt_inc;
                        if (cnt_inc == wlen_c) begin
                            // deliver
                            fin     = 1'b1;
                            state_d = ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        // wait
                        state_d = ST_HOLD;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            left_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            left_q  <= left_d;
        end
    end

    assign word     = sh_d;
    assign fin_left = left_q;

    // R3: while collecting, nothing sits below the next insertion point.
    p_lsb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT || state_q == ST_SKIP) |->
            ((sh_q & ({MAXW{1'b1}} >> cnt_q)) == '0));

    // R2: a word in progress never exceeds the programmed length.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (cnt_q < wlen_c));

    // R5: the skip state exists only in delayed framing.
    p_skip_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> cfg_late);

    // R10: after delivery, later bits of the slot leave the state alone.
    p_hold_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !ev) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/asr_out_stage.sv
`timescale 1ns/1ps
module asr_out_stage
    import asr_pkg::*;
#(
    parameter int unsigned MAXW = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fin,
    input  logic            fin_left,
    input  logic [MAXW-1:0] word,
    output logic [MAXW-1:0] ch_data [NUM_CH],
    output logic            ch_vld  [NUM_CH]
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = fin && (fin_left == (c == CH_LEFT));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_data[c] <= '0;
                ch_vld[c]  <= 1'b0;
            end else begin
                ch_vld[c] <= sel;
                if (sel)
                    ch_data[c] <= word;
            end
        end

        // R9: a strobe lasts one cycle.
        p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ch_vld[c] |=> !ch_vld[c]);

        // R9: data moves only together with its strobe.
        p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_data[c] != $past(ch_data[c])) |-> ch_vld[c]);
    end

    // R8: a word belongs to exactly one channel.
    p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_vld[CH_LEFT], ch_vld[CH_RIGHT]}));

endmodule

// File: rtl/asr_stereo_rx.sv
`timescale 1ns/1ps
module asr_stereo_rx
    import asr_pkg::*;
#(
    parameter  int unsigned MAXW   = 20,
    parameter  int unsigned MINW   = 4,
    parameter  int unsigned STAGES = 2,
    localparam int unsigned LENW   = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_bclk,
    input  logic            ser_lrclk,
    input  logic            ser_wclk,
    input  logic            ser_data,
    input  logic [LENW-1:0] cfg_wlen,
    input  logic            cfg_late,
    input  logic            cfg_wck_sel,
    input  logic            cfg_neg_edge,
    input  logic            cfg_left_low,
    output logic [MAXW-1:0] left_data,
    output logic            left_vld,
    output logic [MAXW-1:0] right_data,
    output logic            right_vld
);

    logic            act, s_bit, s_lr, s_wck;
    logic            fin, fin_left;
    logic [MAXW-1:0] word;
    logic [MAXW-1:0] ch_data [NUM_CH];
    logic            ch_vld  [NUM_CH];

    asr_bclk_edge #(.STAGES(STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_bclk (ser_bclk),
        .raw_lrclk(ser_lrclk),
        .raw_wclk (ser_wclk),
        .raw_data (ser_data),
        .neg_edge (cfg_neg_edge),
        .act      (act),
        .bit_o    (s_bit),
        .lr_o     (s_lr),
        .wck_o    (s_wck)
    );

    asr_frame_fsm #(.MAXW(MAXW), .MINW(MINW), .LENW(LENW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .bit_i       (s_bit),
        .lr_i        (s_lr),
        .wck_i       (s_wck),
        .cfg_wlen    (cfg_wlen),
        .cfg_late    (cfg_late),
        .cfg_wck_sel (cfg_wck_sel),
        .cfg_left_low(cfg_left_low),
        .fin         (fin),
        .fin_left    (fin_left),
        .word        (word)
    );

    asr_out_stage #(.MAXW(MAXW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin     (fin),
        .fin_left(fin_left),
        .word    (word),
        .ch_data (ch_data),
        .ch_vld  (ch_vld)
    );

    assign left_data  = ch_data[CH_LEFT];
    assign left_vld   = ch_vld[CH_LEFT];
    assign right_data = ch_data[CH_RIGHT];
    assign right_vld  = ch_vld[CH_RIGHT];

    // R1: reset value seen right after reset release.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!left_vld && !right_vld && left_data == '0 && right_data == '0));

endmodule

// File: tb/test_asr_stereo_rx.sv
`timescale 1ns/1ps
module test_asr_stereo_rx;

    localparam int HALF = 40;
    localparam int SLOT = 24;
    localparam int WOFF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bclk = 1'b0, ser_lrclk = 1'b0, ser_wclk = 1'b0, ser_data = 1'b0;
    logic [4:0]  cfg_wlen = 5'd20;
    logic        cfg_late = 1'b0, cfg_wck_sel = 1'b0, cfg_neg_edge = 1'b0, cfg_left_low = 1'b0;
    logic [19:0] left_data, right_data;
    logic        left_vld, right_vld;

    int          n_chk = 0;
    int          n_bad = 0;
    string       tag = "R4";
    logic [19:0] ql[$];
    logic [19:0] qr[$];
    logic        prev_lv = 1'b0, prev_rv = 1'b0;
    logic        hold_bad_l = 1'b0, hold_bad_r = 1'b0;
    logic [19:0] last_l = '0, last_r = '0;
    int unsigned seed_v;

    always #5 clk = ~clk;

    asr_stereo_rx i_asr_stereo_rx (
        .clk(clk), .rst_n(rst_n),
        .ser_bclk(ser_bclk), .ser_lrclk(ser_lrclk), .ser_wclk(ser_wclk), .ser_data(ser_data),
        .cfg_wlen(cfg_wlen), .cfg_late(cfg_late), .cfg_wck_sel(cfg_wck_sel),
        .cfg_neg_edge(cfg_neg_edge), .cfg_left_low(cfg_left_low),
        .left_data(left_data), .left_vld(left_vld),
        .right_data(right_data), .right_vld(right_vld)
    );

    task automatic chk(input bit ok, input string req, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Word length rule (R2) and left-justify with zero fill (R3).
    function automatic logic [19:0] exp_word(input logic [19:0] w, input int req);
        int wl;
        wl = (req < 4) ? 4 : (req > 20) ? 20 : req;
        return w & (20'hFFFFF << (20 - wl));
    endfunction

    // Monitor away from the active clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!left_vld && left_data != last_l) hold_bad_l = 1'b1;
            if (!right_vld && right_data != last_r) hold_bad_r = 1'b1;
            if (left_vld) begin
                chk(!prev_lv && !hold_bad_l, "R9", {19'd0, prev_lv}, 20'd0);
                hold_bad_l = 1'b0;
                if (ql.size() == 0) chk(1'b0, {tag, " left unexpected"}, left_data, 20'd0);
                else begin
                    logic [19:0] e;
                    e = ql.pop_front();
                    chk(left_data == e, {tag, " left"}, left_data, e);
                end
            end
            if (right_vld) begin
                chk(!prev_rv && !hold_bad_r, "R9", {19'd0, prev_rv}, 20'd0);
                hold_bad_r = 1'b0;
                if (qr.size() == 0) chk(1'b0, {tag, " right unexpected"}, right_data, 20'd0);
                else begin
                    logic [19:0] e;
                    e = qr.pop_front();
                    chk(right_data == e, {tag, " right"}, right_data, e);
                end
            end
            prev_lv = left_vld;
            prev_rv = right_vld;
            last_l  = left_data;
            last_r  = right_data;
        end
    end

    task automatic send_bit(input logic d, input logic lr, input logic wk);
        ser_bclk  = cfg_neg_edge;
        ser_data  = d;
        ser_lrclk = lr;
        ser_wclk  = wk;
        #HALF;
        ser_bclk = ~cfg_neg_edge;
        #HALF;
    endtask

    task automatic idle_bits();
        for (int i = 0; i < 2; i++)
            send_bit(1'($urandom), cfg_left_low, 1'b0);
    endtask

    // One frame: left slot then right slot, junk after the word (R10).
    task automatic send_frame(input logic [19:0] l, input logic [19:0] r);
        int off;
        off = (cfg_wck_sel ? WOFF : 0) + (cfg_late ? 1 : 0);
        ql.push_back(exp_word(l, int'(cfg_wlen)));
        qr.push_back(exp_word(r, int'(cfg_wlen)));
        for (int ch = 0; ch < 2; ch++) begin
            logic [19:0] w;
            logic        lvl;
            w   = (ch == 0) ? l : r;
            lvl = (ch == 0) ^ cfg_left_low;
            for (int i = 0; i < SLOT; i++) begin
                int   pos;
                logic b;
                pos = i - off;
                b   = (pos >= 0 && pos < 20) ? w[19 - pos] : 1'($urandom);
                send_bit(b, lvl, cfg_wck_sel && (i == WOFF || i == WOFF + 1));
            end
        end
    endtask

    task automatic setup(input int wl, input logic late, input logic wsel,
                         input logic neg, input logic inv, input string t);
        cfg_wlen     = 5'(wl);
        cfg_late     = late;
        cfg_wck_sel  = wsel;
        cfg_neg_edge = neg;
        cfg_left_low = inv;
        tag          = t;
        idle_bits();
    endtask

    initial begin
        seed_v = 32'h1A2B3C4D;
        void'($urandom(seed_v));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!left_vld && !right_vld, "R1 valids in reset", {18'd0, left_vld, right_vld}, 20'd0);
        chk(left_data == 0 && right_data == 0, "R1 data in reset", left_data | right_data, 20'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!left_vld && left_data == 0, "R1 after release", left_data, 20'd0);

        setup(20, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        send_frame(20'hA5C3F, 20'h5A3C0);
        send_frame(20'h80001, 20'h7FFFE);
        setup(16, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        send_frame(20'hFFFFF, 20'h12345);
        setup(12, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        send_frame(20'hFFFFF, 20'hFFFFF);
        setup(4, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
        send_frame(20'hD0000, 20'h3FFFF);
        setup(9, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        send_frame(20'h6B2D1, 20'h9E4A7);
        setup(2, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        send_frame(20'hBFFFF, 20'h4FFFF);
        setup(27, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
        send_frame(20'hC0003, 20'h30005);
        setup(18, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        send_frame(20'h11111, 20'hEEEEE);
        setup(20, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        send_frame(20'h96969, 20'h69696);
        setup(13, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        send_frame(20'hF0F0F, 20'h0F0F0);

        for (int k = 0; k < 30; k++) begin
            int wl;
            wl = ($urandom % 8 == 0) ? int'($urandom % 32) : 4 + int'($urandom % 17);
            setup(wl, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R3");
            send_frame(20'($urandom), 20'($urandom));
        end

        setup(20, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(ql.size() == 0, "R9 left words missing", 20'(ql.size()), 20'd0);
        chk(qr.size() == 0, "R9 right words missing", 20'(qr.size()), 20'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL R9: watchdog expired, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule